// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches the already-synchronized input pins of a GPIO bank, organised as ports of eight pins each, and turns selected pin conditions into a single interrupt line. Each pin can trigger on a high level, a low level, a rising edge, a falling edge or any edge. The trigger type of a pin is held in a 24-bit trigger word per port, which spreads the pin's three control bits across three byte lanes. A detected condition sets a sticky status bit. An enable mask decides which status bits reach the interrupt output.

Software reaches every register through a plain register write port and a combinational read port. The status bits are acknowledged through a write-one-to-clear register. The enable, status and trigger registers also have masked aliases. A masked write changes only the pins it selects, so no read-modify-write is needed when two drivers share a port. An edge that arrives in the same cycle as its acknowledge still leaves the status bit set, so software can acknowledge an edge before it services the pin and lose nothing.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every status, enable and trigger register reads zero and `irq_out` is low.
- R2: Trigger code {bit 16+n, bit 8+n, bit n} = 001 makes pin n a level-high source and 000 a level-low source. While the level is active the status bit is set every cycle, so a clear has no lasting effect. Once set, the bit stays set after the level goes away until it is cleared.
- R3: Code 011 sets status bit n one cycle after the pin goes from 0 to 1.
- R4: Code 010 sets status bit n one cycle after the pin goes from 1 to 0.
- R5: Code 110 sets status bit n on either transition. With bit 8+n set and bit 16+n set, polarity is ignored. With bit 8+n clear, bit 16+n is ignored and the pin is level-sensitive.
- R6: Writing the clear register (byte offset 0x70) clears each status bit whose data bit [n] is 1. Zero bits leave status unchanged. Without a clear, a masked status write or a new event, a status bit holds its value.
- R7: If an event occurs on pin n in the same cycle as a clear or masked write of bit n, status bit n is 1 in the next cycle.
- R8: `irq_out` is high exactly when some port has a status bit and the matching enable bit both set. A source whose enable bit is 0 never drives `irq_out`.
- R9: A masked write to enable (0x850) or status (0x840) uses wdata[15:8] as a pin select and wdata[7:0] as the new values. Pins that are not selected keep their bits.
- R10: A masked write to the trigger register (0x860) uses wdata[31:24] as a pin select. A selected pin n takes bits n, 8+n and 16+n from wdata. All other trigger bits are kept.
- R11: A change to the trigger configuration does not, by itself, create an edge event. An edge event only appears in a cycle in which that pin's input differs from its value in the previous cycle.
- R12: Port p's registers sit at base + 4p, with status at 0x40, enable at 0x50, trigger at 0x60 and clear at 0x70. A plain write to status is ignored. The clear register reads zero. An address outside this map, or with bits [1:0] nonzero, has no effect and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address for the write and for the combinational read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NPORTS*8 | Synchronized pin levels, port p at bits [8p+7:8p] |
| irq_out | output | 1 | Bank interrupt |

## Verification
Several properties are checked on every cycle. A status bit never drops unless a clear or masked write touched it. An event always shows up in status the following cycle, even when a clear collides with it. An edge event never appears without an actual change on its pin. The interrupt output only rises after an event, a masked status set or an enable change. The trigger encodings themselves, the masked-field merges and the address map can only be shown by the bench. The bench drives directed edge and level sequences, with a fixed-seed random mix of writes and pin activity, and compares every readback against its own model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int PINS   = 8;
  localparam int CFG_W  = 3 * PINS;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    KIND_STAT = 2'd0,
    KIND_ENAB = 2'd1,
    KIND_TRIG = 2'd2,
    KIND_CLR  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic any_edge;
    logic edge_mode;
    logic pol;
  } trig_cfg_t;

  // Gather the three lane bits that belong to one pin.
  function automatic trig_cfg_t pin_cfg(input logic [CFG_W-1:0] word, input int n);
    trig_cfg_t c;
    c.pol       = word[n];
    c.edge_mode = word[PINS + n];
    c.any_edge  = word[2*PINS + n];
    return c;
  endfunction

  // Event condition of one pin for the present cycle.
  function automatic logic trig_fire(input trig_cfg_t c, input logic cur, input logic prev);
    logic up, down;
    up   = cur & ~prev;
    down = ~cur & prev;
    if (c.edge_mode)
      return c.any_edge ? (up | down) : (c.pol ? up : down);
    return c.pol ? cur : ~cur;
  endfunction

  // Selected bits take new values, the rest keep old ones.
  function automatic logic [PINS-1:0] merge_sel(input logic [PINS-1:0] old,
                                                input logic [PINS-1:0] sel,
                                                input logic [PINS-1:0] val);
    return (old & ~sel) | (val & sel);
  endfunction

  // Per-pin select replicated across the three lanes of a trigger word.
  function automatic logic [CFG_W-1:0] merge_trig(input logic [CFG_W-1:0] old,
                                                  input logic [PINS-1:0]  sel,
                                                  input logic [CFG_W-1:0] val);
    logic [CFG_W-1:0] wide;
    wide = {sel, sel, sel};
    return (old & ~wide) | (val & wide);
  endfunction

  // Status update: acknowledge, then masked override, then events win.
  function automatic logic [PINS-1:0] status_next(input logic [PINS-1:0] old,
                                                  input logic [PINS-1:0] clr,
                                                  input logic [PINS-1:0] sel,
                                                  input logic [PINS-1:0] val,
                                                  input logic [PINS-1:0] fire);
    return merge_sel(old & ~clr, sel, val) | fire;
  endfunction

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NPORTS-1:0] port_hit,
  output reg_kind_e         kind,
  output logic              alias_m
);

  localparam int IDX_W = 2;

  logic             well_formed;
  logic [IDX_W-1:0] idx;

  assign well_formed = (bus_addr[7:6] == 2'b01) && (bus_addr[10:8] == 3'b000) &&
                       (bus_addr[1:0] == 2'b00);
  assign idx         = bus_addr[3:2];
  assign kind        = reg_kind_e'(bus_addr[5:4]);
  assign alias_m     = bus_addr[11];

  for (genvar p = 0; p < NPORTS; p++) begin : g_hit
    assign port_hit[p] = well_formed && (idx == IDX_W'(p));
  end

endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  reg_kind_e         kind,
  input  logic              alias_m,
  input  logic [DATA_W-1:0] wdata,
  output logic [PINS-1:0]   enab,
  output logic [CFG_W-1:0]  trig,
  output logic [PINS-1:0]   clr_bits,
  output logic [PINS-1:0]   set_sel,
  output logic [PINS-1:0]   set_val
);

  logic [PINS-1:0]  enab_q;
  logic [CFG_W-1:0] trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enab_q <= '0;
      trig_q <= '0;
    end else if (wr_hit) begin
      case (kind)
        KIND_ENAB: enab_q <= alias_m ? merge_sel(enab_q, wdata[2*PINS-1:PINS], wdata[PINS-1:0])
                                     : wdata[PINS-1:0];
        KIND_TRIG: trig_q <= alias_m ? merge_trig(trig_q, wdata[DATA_W-1:CFG_W], wdata[CFG_W-1:0])
                                     : wdata[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  assign enab     = enab_q;
  assign trig     = trig_q;
  assign clr_bits = (wr_hit && kind == KIND_CLR && !alias_m) ? wdata[PINS-1:0] : '0;
  assign set_sel  = (wr_hit && kind == KIND_STAT && alias_m) ? wdata[2*PINS-1:PINS] : '0;
  assign set_val  = wdata[PINS-1:0];

endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_in,
  input  logic [CFG_W-1:0]  trig,
  input  logic [PINS-1:0]   clr_bits,
  input  logic [PINS-1:0]   set_sel,
  input  logic [PINS-1:0]   set_val,
  output logic [PINS-1:0]   status,
  output logic [PINS-1:0]   evt,
  output logic [PINS-1:0]   edge_evt
);

  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] status_q;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    trig_cfg_t c;
    assign c           = pin_cfg(trig, n);
    assign evt[n]      = trig_fire(c, pin_in[n], prev_q[n]);
    assign edge_evt[n] = evt[n] & c.edge_mode;
  end

  // The previous-level copy tracks the pin even in reset, so the first
  // cycle after reset compares against a real sample.
  always_ff @(posedge clk) begin
    prev_q <= pin_in;
    if (!rst_n) status_q <= '0;
    else        status_q <= status_next(status_q, clr_bits, set_sel, set_val, evt);
  end

  assign status = status_q;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NPORTS*PINS-1:0] pin_in,
  output logic                   irq_out
);

  localparam int NBITS = NPORTS * PINS;

  logic [NPORTS-1:0] port_hit;
  reg_kind_e         kind;
  logic              alias_m;

  logic [NBITS-1:0]  stat_vec;
  logic [NBITS-1:0]  enab_vec;
  logic [NBITS-1:0]  wipe_vec;
  logic [NBITS-1:0]  set_vec;
  logic [NBITS-1:0]  evt_vec;
  logic [NBITS-1:0]  edge_vec;
  logic [DATA_W-1:0] port_rd [NPORTS];
  logic [DATA_W-1:0] rd_or   [NPORTS+1];

  gpio_irq_decode #(.NPORTS(NPORTS)) u_dec (
    .bus_addr (bus_addr),
    .port_hit (port_hit),
    .kind     (kind),
    .alias_m  (alias_m)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [CFG_W-1:0] trig;
    logic [PINS-1:0]  clr_bits, set_sel, set_val;

    gpio_irq_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (bus_wr && port_hit[p]),
      .kind     (kind),
      .alias_m  (alias_m),
      .wdata    (bus_wdata),
      .enab     (enab_vec[p*PINS +: PINS]),
      .trig     (trig),
      .clr_bits (clr_bits),
      .set_sel  (set_sel),
      .set_val  (set_val)
    );

    gpio_irq_trig u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in[p*PINS +: PINS]),
      .trig     (trig),
      .clr_bits (clr_bits),
      .set_sel  (set_sel),
      .set_val  (set_val),
      .status   (stat_vec[p*PINS +: PINS]),
      .evt      (evt_vec[p*PINS +: PINS]),
      .edge_evt (edge_vec[p*PINS +: PINS])
    );

    assign wipe_vec[p*PINS +: PINS] = clr_bits | set_sel;
    assign set_vec[p*PINS +: PINS]  = set_sel & set_val;

    always_comb begin
      port_rd[p] = '0;
      if (port_hit[p]) begin
        case (kind)
          KIND_STAT: port_rd[p] = DATA_W'(stat_vec[p*PINS +: PINS]);
          KIND_ENAB: port_rd[p] = DATA_W'(enab_vec[p*PINS +: PINS]);
          KIND_TRIG: port_rd[p] = DATA_W'(trig);
          default:   port_rd[p] = '0;
        endcase
      end
    end

    assign rd_or[p+1] = rd_or[p] | port_rd[p];
  end

  assign rd_or[0]  = '0;
  assign bus_rdata = rd_or[NPORTS];
  assign irq_out   = |(stat_vec & enab_vec);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPORTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPORTS*8-1:0] pin_in,
  input logic [NPORTS*8-1:0] stat_vec,
  input logic [NPORTS*8-1:0] enab_vec,
  input logic [NPORTS*8-1:0] wipe_vec,
  input logic [NPORTS*8-1:0] set_vec,
  input logic [NPORTS*8-1:0] evt_vec,
  input logic [NPORTS*8-1:0] edge_vec,
  input logic                irq_out
);

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_vec) & ~$past(wipe_vec) & ~stat_vec) == '0));

  // R7
  event_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_vec) & ~stat_vec) == '0));

  // R11
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_vec & ~(pin_in ^ $past(pin_in))) == '0));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(|(evt_vec | set_vec)) || !$stable(enab_vec)));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_in   (pin_in),
  .stat_vec (stat_vec),
  .enab_vec (enab_vec),
  .wipe_vec (wipe_vec),
  .set_vec  (set_vec),
  .evt_vec  (evt_vec),
  .edge_vec (edge_vec),
  .irq_out  (irq_out)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;

  localparam int NP = 4;
  localparam int NB = NP * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NB-1:0] pins = '1;
  logic          irq_out;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [NB-1:0] m_stat, m_en, m_prev;
  logic [23:0]   m_lvl [NP];

  always #10 clk = ~clk;

  gpio_irq_bank #(.NPORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic fires(input logic [2:0] code, input logic c, input logic o);
    case (code)
      3'b011:         return c && !o;
      3'b010:         return !c && o;
      3'b110, 3'b111: return c != o;
      3'b001, 3'b101: return c;
      default:        return !c;
    endcase
  endfunction

  // One clock: model the edge, then read back status of port rp.
  task automatic cycle(input string tag, input int rp);
    logic [NB-1:0] n_stat, n_en, f;
    logic [23:0]   n_lvl [NP];
    logic [3:0]    k;
    int            p;
    bit            ok;
    n_stat = m_stat; n_en = m_en;
    for (int q = 0; q < NP; q++) n_lvl[q] = m_lvl[q];
    for (int i = 0; i < NB; i++)
      f[i] = fires({m_lvl[i/8][16+i%8], m_lvl[i/8][8+i%8], m_lvl[i/8][i%8]}, pins[i], m_prev[i]);
    k  = bus_addr[7:4];
    p  = int'(bus_addr[3:2]);
    ok = bus_wr && bus_addr[10:8] == 0 && bus_addr[1:0] == 0 && k >= 4 && p < NP;
    if (ok) begin
      for (int n = 0; n < 8; n++) begin
        case ({bus_addr[11], k})
          5'h05: n_en[p*8+n] = bus_wdata[n];
          5'h15: if (bus_wdata[8+n]) n_en[p*8+n] = bus_wdata[n];
          5'h06: begin
            n_lvl[p][n] = bus_wdata[n]; n_lvl[p][8+n] = bus_wdata[8+n]; n_lvl[p][16+n] = bus_wdata[16+n];
          end
          5'h16: if (bus_wdata[24+n]) begin
            n_lvl[p][n] = bus_wdata[n]; n_lvl[p][8+n] = bus_wdata[8+n]; n_lvl[p][16+n] = bus_wdata[16+n];
          end
          5'h07: if (bus_wdata[n]) n_stat[p*8+n] = 1'b0;
          5'h14: if (bus_wdata[8+n]) n_stat[p*8+n] = bus_wdata[n];
          default: ;
        endcase
      end
    end
    for (int i = 0; i < NB; i++) if (f[i]) n_stat[i] = 1'b1;
    m_prev = pins;
    @(posedge clk);
    #2;
    m_stat = n_stat; m_en = n_en;
    for (int q = 0; q < NP; q++) m_lvl[q] = n_lvl[q];
    bus_wr   = 1'b0;
    bus_addr = {4'h0, 4'h4, 2'(rp), 2'b00};
    #1;
    check(tag, bus_rdata, {24'h0, m_stat[rp*8 +: 8]});
    check(tag, {31'h0, irq_out}, {31'h0, |(m_stat & m_en)});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag, input int rp);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cycle(tag, rp);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_stat = '0; m_en = '0; m_prev = pins;
    for (int q = 0; q < NP; q++) m_lvl[q] = '0;
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(12'h040, 0, "R1"); rd(12'h050, 0, "R1"); rd(12'h060, 0, "R1");
    check("R1", {31'h0, irq_out}, 0);

    // R11: switching pin0 to rising while it sits high gives no event
    wr(12'h060, 32'h0000_0101, "R11", 0);
    cycle("R11", 0);
    rd(12'h040, 0, "R11");
    // R3 rising edge
    pins[0] = 1'b0; cycle("R3", 0);
    pins[0] = 1'b1; cycle("R3", 0);
    rd(12'h040, 32'h1, "R3");
    // R6 write-one-to-clear
    wr(12'h070, 32'h0, "R6", 0); rd(12'h040, 32'h1, "R6");
    wr(12'h070, 32'h1, "R6", 0); rd(12'h040, 32'h0, "R6");
    // R7 edge collides with clear
    pins[0] = 1'b0; cycle("R7", 0);
    pins[0] = 1'b1; wr(12'h070, 32'h1, "R7", 0);
    rd(12'h040, 32'h1, "R7");
    // R8 enable gating
    check("R8", {31'h0, irq_out}, 0);
    wr(12'h050, 32'h1, "R8", 0); check("R8", {31'h0, irq_out}, 1);
    wr(12'h070, 32'h1, "R8", 0); check("R8", {31'h0, irq_out}, 0);
    // R10 masked trigger write, pin1 falling
    wr(12'h860, 32'h0200_0200, "R10", 0);
    rd(12'h060, 32'h0000_0301, "R10");
    // R4 falling edge
    pins[1] = 1'b0; cycle("R4", 0);
    rd(12'h040, 32'h2, "R4");
    // R5 both edges on pin2
    wr(12'h860, 32'h0404_0400, "R5", 0);
    pins[2] = 1'b0; cycle("R5", 0); rd(12'h040, 32'h6, "R5");
    wr(12'h070, 32'h4, "R5", 0);    rd(12'h040, 32'h2, "R5");
    pins[2] = 1'b1; cycle("R5", 0); rd(12'h040, 32'h6, "R5");
    // R2 level high on pin3, clear does not hold while active
    wr(12'h860, 32'h0800_0008, "R2", 0);
    cycle("R2", 0);
    wr(12'h070, 32'h8, "R2", 0); rd(12'h040, 32'h0E, "R2");
    pins[3] = 1'b0; cycle("R2", 0);
    wr(12'h070, 32'h8, "R2", 0); rd(12'h040, 32'h06, "R2");
    // R2 level low on pin4
    wr(12'h860, 32'h1000_0000, "R2", 0);
    pins[4] = 1'b0; cycle("R2", 0); rd(12'h040, 32'h16, "R2");
    // R9 masked enable and masked status
    wr(12'h850, 32'h0000_0C04, "R9", 0); rd(12'h050, 32'h05, "R9");
    wr(12'h840, 32'h0000_0300, "R9", 0); rd(12'h040, 32'h14, "R9");
    // R12 address map
    wr(12'h058, 32'hA5, "R12", 2);
    rd(12'h058, 32'hA5, "R12"); rd(12'h050, 32'h05, "R12"); rd(12'h078, 0, "R12");
    wr(12'h040, 32'hFF, "R12", 0); rd(12'h040, 32'h14, "R12");
    wr(12'h052, 32'hFF, "R12", 0); rd(12'h050, 32'h05, "R12"); rd(12'h052, 0, "R12");

    // Random mix, all against the model (R8 output, status per port)
    for (int t = 0; t < 3000; t++) begin
      int sel;
      int port;
      logic [31:0] d;
      pins = pins ^ ($urandom & $urandom & $urandom);
      sel  = $urandom % 10;
      port = $urandom % NP;
      d    = $urandom;
      case (sel)
        0, 1, 2: cycle("R8", port);
        3: wr({4'h0, 4'h5, 2'(port), 2'b00}, d, "R8", port);
        4: wr({4'h0, 4'h6, 2'(port), 2'b00}, d, "R8", port);
        5: wr({4'h0, 4'h7, 2'(port), 2'b00}, d, "R6", port);
        6: wr({4'h8, 4'h5, 2'(port), 2'b00}, d, "R9", port);
        7: wr({4'h8, 4'h6, 2'(port), 2'b00}, d, "R10", port);
        8: wr({4'h8, 4'h4, 2'(port), 2'b00}, d, "R9", port);
        default: wr(12'($urandom), d, "R12", port);
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule